// File: doc/BRIEF.md
# Scatter-Gather DMA Chain Sequencer

This block drives one DMA channel through a linked list of transfer descriptors kept in memory. Software sets up the channel through a small register port: a mode word, a command/status byte, PCI and local addresses, a byte count and a descriptor pointer. When chaining is enabled, a start command makes the block read a four-word descriptor: PCI address, local address, byte count, and a next pointer whose low four bits are flags. For each descriptor whose count is not zero, it issues one transfer request on a request/acknowledge port. It then follows the next pointer until it reaches a descriptor that marks the end of the chain.

When chaining is disabled, a start command runs a single transfer from the directly written registers, and no descriptors are read. Descriptor words come in through a one-word memory-read handshake. When clear-count mode is on, the block writes a zero back to each descriptor's count word through a matching write handshake. Completion, per-descriptor terminal-count requests and abort all pass through a done flag and a sticky interrupt. That interrupt is routed to either a PCI-side or a local-side output.

Top module: `sgdma_chain_seq`

## Requirements
- R1: After reset the command/status byte reads 0x10 (done set, enable clear), the mode reads 0, both interrupt outputs are low and no request is raised.
- R2: Register 1 is the command/status byte: bit 0 enable (read/write), bit 1 start, bit 2 abort and bit 3 clear-interrupt (write-one strobes), bit 4 done (read-only). A start is accepted only when enable and done are both 1, and done then reads 0. Otherwise the start is ignored.
- R3: Mode register 0 has four fields: bit 0 chaining, bit 1 done-interrupt enable, bit 2 clear-count and bit 3 interrupt select. With chaining on, a start reads four words at the pointer with bits 3:0 cleared, at offsets 0, 4, 8 and 12: PCI address, local address, count, next pointer. Each read targets PCI-side memory (`mrd_space`=1) when bit 0 of the pointer that led to that descriptor is 1.
- R4: Bits 3:0 of a descriptor's fourth word are its flags: bit 3 sets direction (1 = local-to-PCI), bit 1 ends the chain, and bit 2 requests an interrupt when the descriptor completes. Bits 31:4 plus bit 0 form the pointer to the next descriptor.
- R5: Each descriptor with a nonzero count issues exactly one transfer request, in chain order. The request carries its addresses, the low 23 bits of its count and its direction, and it is held steady until acknowledged.
- R6: A descriptor whose low 23 count bits are zero raises no transfer request, and the chain continues.
- R7: With chaining off, a start issues one transfer from registers 2 (PCI address), 3 (local address) and 4 (count), with direction taken from bit 3 of register 5, and reads no descriptors.
- R8: With chaining and clear-count on, after each descriptor's transfer the block writes zero to that descriptor's offset 8, in the same memory space it was read from.
- R9: The interrupt is set on chain or single completion when the done-interrupt enable is set, and on completion of any chained descriptor flagged by bit 2. It appears on `irq_pci` when mode bit 3 is 1, otherwise on `irq_local`, and never on both.
- R10: The interrupt stays set until a clear-interrupt strobe. If a new interrupt event falls in the same cycle as the clear, the interrupt stays set.
- R11: An abort while done is 0 sets done within one cycle, drops all requests and raises no interrupt. An abort while done is 1 has no effect.
- R12: Register 4 keeps only its low 23 bits and reads back zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and readback |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the register at reg_addr |
| mrd_req | output | 1 | Descriptor word read request |
| mrd_addr | output | 32 | Descriptor word byte address |
| mrd_space | output | 1 | 1 = PCI-side memory, 0 = local-side |
| mrd_ack | input | 1 | Read acknowledge, data valid |
| mrd_data | input | 32 | Read data |
| xfr_req | output | 1 | Transfer request |
| xfr_pci_addr | output | 32 | Transfer PCI address |
| xfr_loc_addr | output | 32 | Transfer local address |
| xfr_count | output | 23 | Transfer byte count |
| xfr_l2p | output | 1 | 1 = local-to-PCI, 0 = PCI-to-local |
| xfr_ack | input | 1 | Transfer acknowledge |
| mwr_req | output | 1 | Count clear write request (data is zero) |
| mwr_addr | output | 32 | Count word byte address |
| mwr_space | output | 1 | Memory space of the write |
| mwr_ack | input | 1 | Write acknowledge |
| irq_pci | output | 1 | Channel interrupt, PCI-side routing |
| irq_local | output | 1 | Channel interrupt, local-side routing |

## Verification
A wrong fetch index or a wrong pointer update appears at the transfer port on the next descriptor. It shows as a wrong address or count, or as a wrong number of transfers, within one descriptor fetch, which is eight cycles. A stuck or wrongly updated done flag shows in the next command/status readback, as a start that is not ignored or an abort that has no effect. A lost interrupt event or a lost interrupt clear shows on the interrupt lines in the cycle after the chain finishes or after the clear. Sweeping chain length, the mode options, zero-length descriptors and alternating memory spaces drives every state path through these ports.

// File: rtl/sgdma_pkg.sv
// Shared types and constants for the scatter-gather chain sequencer.
// Assumes descriptors are 16-byte aligned so pointer bits 3:0 are flags.
package sgdma_pkg;

    // Register indices on the programming port
    localparam logic [2:0] RA_MODE = 3'd0;
    localparam logic [2:0] RA_CSR  = 3'd1;
    localparam logic [2:0] RA_PCI  = 3'd2;
    localparam logic [2:0] RA_LOC  = 3'd3;
    localparam logic [2:0] RA_SIZE = 3'd4;
    localparam logic [2:0] RA_DPTR = 3'd5;

    // Command/status bit positions (software decodes them)
    localparam int CS_EN    = 0;
    localparam int CS_START = 1;
    localparam int CS_ABORT = 2;
    localparam int CS_CLR   = 3;
    localparam int CS_DONE  = 4;

    // Descriptor pointer flag positions
    localparam int FL_SPACE = 0;
    localparam int FL_LAST  = 1;
    localparam int FL_TC    = 2;
    localparam int FL_L2P   = 3;

    // Number of 32-bit words in one descriptor
    localparam int DESC_WORDS = 4;

    // Mode word, packed so field order matches bit positions 3..0
    typedef struct packed {
        logic irq_sel_pci;
        logic clr_count;
        logic done_ie;
        logic chain_en;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_XFER  = 2'd2,
        ST_WB    = 2'd3
    } seq_state_t;

endpackage

// File: rtl/sgdma_regs.sv
// Programming register file: holds mode, enable, addresses, size and
// descriptor pointer; decodes the write-one strobes; drives readback.
// Assumes DATA_W >= CNT_W + 1 and DATA_W >= 8.
module sgdma_regs
    import sgdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              done_i,
    output mode_t             mode_o,
    output logic              enable_o,
    output logic [DATA_W-1:0] pci_o,
    output logic [DATA_W-1:0] loc_o,
    output logic [CNT_W-1:0]  size_o,
    output logic [DATA_W-1:0] dptr_o,
    output logic              start_o,
    output logic              abort_o,
    output logic              clr_o
);

    logic csr_wr;
    assign csr_wr = reg_wr && (reg_addr == RA_CSR);

    // Write-one strobes, valid only in the write cycle
    assign start_o = csr_wr && reg_wdata[CS_START];
    assign abort_o = csr_wr && reg_wdata[CS_ABORT];
    assign clr_o   = csr_wr && reg_wdata[CS_CLR];

    // Register storage updated by software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o   <= '0;
            enable_o <= 1'b0;
            pci_o    <= '0;
            loc_o    <= '0;
            size_o   <= '0;
            dptr_o   <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_MODE: mode_o   <= mode_t'(reg_wdata[3:0]);
                RA_CSR:  enable_o <= reg_wdata[CS_EN];
                RA_PCI:  pci_o    <= reg_wdata;
                RA_LOC:  loc_o    <= reg_wdata;
                RA_SIZE: size_o   <= reg_wdata[CNT_W-1:0];
                RA_DPTR: dptr_o   <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Readback multiplexer
    always_comb begin
        case (reg_addr)
            RA_MODE: reg_rdata = DATA_W'(mode_o);
            RA_CSR:  reg_rdata = DATA_W'({done_i, 3'b000, enable_o});
            RA_PCI:  reg_rdata = pci_o;
            RA_LOC:  reg_rdata = loc_o;
            RA_SIZE: reg_rdata = DATA_W'(size_o);
            RA_DPTR: reg_rdata = dptr_o;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sgdma_irq.sv
// Sticky channel interrupt: set by an event, cleared by software, with
// a same-cycle event taking precedence; routed to one of two outputs.
module sgdma_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic clr_i,
    input  logic sel_pci_i,
    output logic pend_o,
    output logic irq_pci,
    output logic irq_local
);

    // Pending flag: event wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_o <= 1'b0;
        else if (event_i) pend_o <= 1'b1;
        else if (clr_i)   pend_o <= 1'b0;
    end

    // Route to exactly one side
    assign irq_pci   = pend_o &&  sel_pci_i;
    assign irq_local = pend_o && !sel_pci_i;

endmodule

// File: rtl/sgdma_ctrl.sv
// Channel sequencer: fetches descriptors one word per handshake, issues
// one transfer per nonzero descriptor, optionally clears the stored count,
// follows the chain, and handles abort and completion events.
// Assumes requests may be withdrawn when an abort is taken.
module sgdma_ctrl
    import sgdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_t             mode_i,
    input  logic              enable_i,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [DATA_W-1:0] reg_pci_i,
    input  logic [DATA_W-1:0] reg_loc_i,
    input  logic [CNT_W-1:0]  reg_size_i,
    input  logic [DATA_W-1:0] reg_dptr_i,
    output logic              done_o,
    output logic              event_o,
    output logic              mrd_req,
    output logic [DATA_W-1:0] mrd_addr,
    output logic              mrd_space,
    input  logic              mrd_ack,
    input  logic [DATA_W-1:0] mrd_data,
    output logic              xfr_req,
    output logic [DATA_W-1:0] xfr_pci_addr,
    output logic [DATA_W-1:0] xfr_loc_addr,
    output logic [CNT_W-1:0]  xfr_count,
    output logic              xfr_l2p,
    input  logic              xfr_ack,
    output logic              mwr_req,
    output logic [DATA_W-1:0] mwr_addr,
    output logic              mwr_space,
    input  logic              mwr_ack
);

    localparam int WIDX_W = $clog2(DESC_WORDS);
    localparam logic [DATA_W-1:0] CNT_OFS = DATA_W'(8);

    seq_state_t          st_q;
    logic [WIDX_W-1:0]   widx_q;
    logic [DATA_W-1:0]   cur_ptr_q;
    logic [DATA_W-1:0]   d_pci_q;
    logic [DATA_W-1:0]   d_loc_q;
    logic [CNT_W-1:0]    d_cnt_q;
    logic [DATA_W-1:0]   d_next_q;
    logic                chained_q;
    logic                done_q;

    logic [DATA_W-1:0]   cur_base;
    logic                cnt_zero;
    logic                abort_hit;
    logic                fin;
    logic                go_wb;
    logic                unused_ptr_bits;

    assign cur_base        = {cur_ptr_q[DATA_W-1:4], 4'b0000};
    assign cnt_zero        = (d_cnt_q == '0);
    assign abort_hit       = abort_i && !done_q;
    assign unused_ptr_bits = ^cur_ptr_q[3:1];

    assign done_o       = done_q;
    assign mrd_addr     = cur_base | DATA_W'({widx_q, 2'b00});
    assign mrd_space    = cur_ptr_q[FL_SPACE];
    assign xfr_pci_addr = d_pci_q;
    assign xfr_loc_addr = d_loc_q;
    assign xfr_count    = d_cnt_q;
    assign xfr_l2p      = d_next_q[FL_L2P];
    assign mwr_addr     = cur_base | CNT_OFS;
    assign mwr_space    = cur_ptr_q[FL_SPACE];

    // Request decode and end-of-descriptor detection
    always_comb begin
        mrd_req = 1'b0;
        xfr_req = 1'b0;
        mwr_req = 1'b0;
        fin     = 1'b0;
        go_wb   = 1'b0;
        case (st_q)
            ST_FETCH: mrd_req = 1'b1;
            ST_XFER: begin
                xfr_req = !cnt_zero;
                if (cnt_zero || xfr_ack) begin
                    if (chained_q && mode_i.clr_count) go_wb = 1'b1;
                    else                               fin   = 1'b1;
                end
            end
            ST_WB: begin
                mwr_req = 1'b1;
                fin     = mwr_ack;
            end
            default: ;
        endcase
    end

    // Interrupt event on descriptor completion (none on abort)
    assign event_o = fin && !abort_hit &&
                     ((chained_q && d_next_q[FL_TC]) ||
                      (d_next_q[FL_LAST] && mode_i.done_ie));

    // Sequencer state, descriptor capture and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            widx_q    <= '0;
            cur_ptr_q <= '0;
            d_pci_q   <= '0;
            d_loc_q   <= '0;
            d_cnt_q   <= '0;
            d_next_q  <= '0;
            chained_q <= 1'b0;
            done_q    <= 1'b1;
        end else if (abort_hit) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
        end else if (fin) begin
            if (d_next_q[FL_LAST]) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
            end else begin
                cur_ptr_q <= d_next_q;
                widx_q    <= '0;
                st_q      <= ST_FETCH;
            end
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i && enable_i && done_q) begin
                        done_q    <= 1'b0;
                        chained_q <= mode_i.chain_en;
                        if (mode_i.chain_en) begin
                            cur_ptr_q <= reg_dptr_i;
                            widx_q    <= '0;
                            st_q      <= ST_FETCH;
                        end else begin
                            d_pci_q  <= reg_pci_i;
                            d_loc_q  <= reg_loc_i;
                            d_cnt_q  <= reg_size_i;
                            d_next_q <= {reg_dptr_i[DATA_W-1:4],
                                         reg_dptr_i[FL_L2P], 1'b0, 1'b1, 1'b0};
                            st_q     <= ST_XFER;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mrd_ack) begin
                        case (widx_q)
                            WIDX_W'(0): d_pci_q  <= mrd_data;
                            WIDX_W'(1): d_loc_q  <= mrd_data;
                            WIDX_W'(2): d_cnt_q  <= mrd_data[CNT_W-1:0];
                            default:    d_next_q <= mrd_data;
                        endcase
                        widx_q <= widx_q + 1'b1;
                        if (widx_q == WIDX_W'(DESC_WORDS - 1)) st_q <= ST_XFER;
                    end
                end
                ST_XFER: if (go_wb) st_q <= ST_WB;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sgdma_chain_seq.sv
// Top of the scatter-gather DMA chain sequencer: connects the register
// file, the sequencer and the interrupt flag.
module sgdma_chain_seq
    import sgdma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mrd_req,
    output logic [DATA_W-1:0] mrd_addr,
    output logic              mrd_space,
    input  logic              mrd_ack,
    input  logic [DATA_W-1:0] mrd_data,
    output logic              xfr_req,
    output logic [DATA_W-1:0] xfr_pci_addr,
    output logic [DATA_W-1:0] xfr_loc_addr,
    output logic [CNT_W-1:0]  xfr_count,
    output logic              xfr_l2p,
    input  logic              xfr_ack,
    output logic              mwr_req,
    output logic [DATA_W-1:0] mwr_addr,
    output logic              mwr_space,
    input  logic              mwr_ack,
    output logic              irq_pci,
    output logic              irq_local
);

    mode_t             mode;
    logic              enable;
    logic              done;
    logic [DATA_W-1:0] r_pci;
    logic [DATA_W-1:0] r_loc;
    logic [CNT_W-1:0]  r_size;
    logic [DATA_W-1:0] r_dptr;
    logic              start_s;
    logic              abort_s;
    logic              clr_s;
    logic              irq_ev;
    logic              irq_pend;

    sgdma_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .done_i   (done),
        .mode_o   (mode),
        .enable_o (enable),
        .pci_o    (r_pci),
        .loc_o    (r_loc),
        .size_o   (r_size),
        .dptr_o   (r_dptr),
        .start_o  (start_s),
        .abort_o  (abort_s),
        .clr_o    (clr_s)
    );

    sgdma_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .enable_i    (enable),
        .start_i     (start_s),
        .abort_i     (abort_s),
        .reg_pci_i   (r_pci),
        .reg_loc_i   (r_loc),
        .reg_size_i  (r_size),
        .reg_dptr_i  (r_dptr),
        .done_o      (done),
        .event_o     (irq_ev),
        .mrd_req     (mrd_req),
        .mrd_addr    (mrd_addr),
        .mrd_space   (mrd_space),
        .mrd_ack     (mrd_ack),
        .mrd_data    (mrd_data),
        .xfr_req     (xfr_req),
        .xfr_pci_addr(xfr_pci_addr),
        .xfr_loc_addr(xfr_loc_addr),
        .xfr_count   (xfr_count),
        .xfr_l2p     (xfr_l2p),
        .xfr_ack     (xfr_ack),
        .mwr_req     (mwr_req),
        .mwr_addr    (mwr_addr),
        .mwr_space   (mwr_space),
        .mwr_ack     (mwr_ack)
    );

    sgdma_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_i  (irq_ev),
        .clr_i    (clr_s),
        .sel_pci_i(mode.irq_sel_pci),
        .pend_o   (irq_pend),
        .irq_pci  (irq_pci),
        .irq_local(irq_local)
    );

endmodule

// File: rtl/sgdma_chain_seq_chk.sv
// Checker for the chain sequencer: handshake stability, zero-count skip,
// start/abort effect on done, and interrupt routing and stickiness.
module sgdma_chain_seq_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_s,
    input logic              abort_s,
    input logic              clr_s,
    input logic              enable,
    input logic              done,
    input logic              irq_ev,
    input logic              irq_pend,
    input logic              xfr_req,
    input logic              xfr_ack,
    input logic [DATA_W-1:0] xfr_pci_addr,
    input logic [CNT_W-1:0]  xfr_count,
    input logic              mrd_req,
    input logic              mwr_req,
    input logic              irq_pci,
    input logic              irq_local
);

    // R1: an idle channel raises no request
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(xfr_req || mrd_req || mwr_req));

    // R2: an accepted start clears done
    a_r2_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        start_s && enable && done && !abort_s |=> !done);

    // R5: a pending transfer request holds its fields
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        xfr_req && !xfr_ack && !abort_s |=>
            xfr_req && $stable(xfr_pci_addr) && $stable(xfr_count));

    // R6: no transfer request carries a zero count
    a_r6_no_zero_req: assert property (@(posedge clk) disable iff (!rst_n)
        xfr_req |-> (xfr_count != '0));

    // R9: interrupt appears on at most one side
    a_r9_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pci && irq_local));

    // R10: interrupt stays until cleared
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pci || irq_local) && !clr_s |=> (irq_pci || irq_local));

    // R10: an event in the clear cycle wins
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ev && clr_s |=> irq_pend);

    // R11: abort of an active channel sets done and drops requests
    a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort_s && !done |=> done && !xfr_req && !mrd_req && !mwr_req);

endmodule

bind sgdma_chain_seq sgdma_chain_seq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_s     (start_s),
    .abort_s     (abort_s),
    .clr_s       (clr_s),
    .enable      (enable),
    .done        (done),
    .irq_ev      (irq_ev),
    .irq_pend    (irq_pend),
    .xfr_req     (xfr_req),
    .xfr_ack     (xfr_ack),
    .xfr_pci_addr(xfr_pci_addr),
    .xfr_count   (xfr_count),
    .mrd_req     (mrd_req),
    .mwr_req     (mwr_req),
    .irq_pci     (irq_pci),
    .irq_local   (irq_local)
);

// File: tb/sim_sgdma_chain_seq.sv
// Bench: sweeps chain length and mode options with memory and transfer
// models, then checks single mode, gating of start, abort and size width.
module sim_sgdma_chain_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int CW = 23;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          mrd_req, mrd_space, xfr_req, xfr_l2p, mwr_req, mwr_space;
    logic [DW-1:0] mrd_addr, xfr_pci_addr, xfr_loc_addr, mwr_addr;
    logic [CW-1:0] xfr_count;
    logic          mrd_ack = 1'b0, xfr_ack = 1'b0, mwr_ack = 1'b0;
    logic [DW-1:0] mrd_data = '0;
    logic          irq_pci, irq_local;

    logic [31:0] pci_mem [0:63];
    logic [31:0] loc_mem [0:63];
    logic [31:0] log_pci [0:7];
    logic [31:0] log_loc [0:7];
    logic [22:0] log_cnt [0:7];
    logic        log_dir [0:7];
    int          n_xfr = 0;
    int          n_mrd = 0;
    bit          hold_xfr = 1'b0;
    int          n_chk = 0;
    int          n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sgdma_chain_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_space(mrd_space),
        .mrd_ack(mrd_ack), .mrd_data(mrd_data),
        .xfr_req(xfr_req), .xfr_pci_addr(xfr_pci_addr), .xfr_loc_addr(xfr_loc_addr),
        .xfr_count(xfr_count), .xfr_l2p(xfr_l2p), .xfr_ack(xfr_ack),
        .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_space(mwr_space), .mwr_ack(mwr_ack),
        .irq_pci(irq_pci), .irq_local(irq_local)
    );

    // Memory, transfer and write responders, acting at the falling edge
    always @(negedge clk) begin
        if (mrd_req && !mrd_ack) begin
            mrd_ack  <= 1'b1;
            mrd_data <= mrd_space ? pci_mem[mrd_addr[7:2]] : loc_mem[mrd_addr[7:2]];
            n_mrd    <= n_mrd + 1;
        end else mrd_ack <= 1'b0;
        if (xfr_req && !xfr_ack && !hold_xfr) begin
            xfr_ack <= 1'b1;
            if (n_xfr < 8) begin
                log_pci[n_xfr] <= xfr_pci_addr;
                log_loc[n_xfr] <= xfr_loc_addr;
                log_cnt[n_xfr] <= xfr_count;
                log_dir[n_xfr] <= xfr_l2p;
            end
            n_xfr <= n_xfr + 1;
        end else xfr_ack <= 1'b0;
        if (mwr_req && !mwr_ack) begin
            mwr_ack <= 1'b1;
            if (mwr_space) pci_mem[mwr_addr[7:2]] <= '0;
            else           loc_mem[mwr_addr[7:2]] <= '0;
        end else mwr_ack <= 1'b0;
    end

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] v;
        int t;
        t = 0;
        do begin rd(3'd1, v); t++; end while (!v[4] && t < 3000);
        chk(v[4] == 1'b1, req, v[4], 1);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    function automatic logic [31:0] dptr_of(input int i);
        return 32'(16 * (i + 1)) | 32'(i % 2);
    endfunction

    initial begin
        logic [31:0] v;
        for (int k = 0; k < 64; k++) begin pci_mem[k] = '0; loc_mem[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports
        rd(3'd1, v); chk(v == 32'h10, "R1 csr", v, 32'h10);
        rd(3'd0, v); chk(v == 32'h0, "R1 mode", v, 0);
        chk({irq_pci, irq_local, xfr_req, mrd_req, mwr_req} == 5'b0, "R1 outputs",
            {irq_pci, irq_local, xfr_req, mrd_req, mwr_req}, 0);

        // R12: size register keeps 23 bits
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, v); chk(v == 32'h007F_FFFF, "R12 size width", v, 32'h007F_FFFF);

        // R2: start ignored while enable is clear
        wr(3'd0, 32'h1); wr(3'd5, 32'h10);
        n_mrd = 0;
        wr(3'd1, 32'h2);
        repeat (4) @(negedge clk);
        rd(3'd1, v); chk(v == 32'h10, "R2 start without enable", v, 32'h10);
        chk(n_mrd == 0 && n_xfr == 0, "R2 no activity", n_mrd + n_xfr, 0);

        // Sweep: chain length 1..4 times eight mode combinations
        for (int len = 1; len <= 4; len++) begin
            for (int opt = 0; opt < 8; opt++) begin
                bit die, clr, sel, expirq;
                int k;
                die = opt[0]; clr = opt[1]; sel = opt[2];
                for (int i = 0; i < len; i++) begin
                    logic [31:0] w [0:3];
                    logic [31:0] nx;
                    w[0] = 32'h1000_0000 + 32'(i * 256 + len * 16 + opt);
                    w[1] = 32'h2000_0000 + 32'(i * 512 + len * 16 + opt);
                    w[2] = (i == 1) ? 32'h0080_0000 : (32'hAB80_0000 | 32'((i + 1) * 100 + opt));
                    nx = (i == len - 1) ? 32'h0 : dptr_of(i + 1);
                    w[3] = {nx[31:4], 1'(i % 2), 1'(i == 0 && len >= 2), 1'(i == len - 1), nx[0]};
                    for (int j = 0; j < 4; j++) begin
                        if (i % 2 == 1) pci_mem[4 * (i + 1) + j] = w[j];
                        else            loc_mem[4 * (i + 1) + j] = w[j];
                    end
                end
                wr(3'd0, {28'd0, sel, clr, die, 1'b1});
                wr(3'd5, dptr_of(0));
                n_xfr = 0;
                wr(3'd1, 32'h1);
                wr(3'd1, 32'h3);
                rd(3'd1, v); chk(v[4] == 1'b0 || len == 1, "R2 done low after start", v[4], 0);
                wait_done("R3 chain completes");
                // R5 R6: one transfer per nonzero descriptor, in order
                chk(n_xfr == ((len > 1) ? len - 1 : len), "R6 transfer count",
                    n_xfr, (len > 1) ? len - 1 : len);
                k = 0;
                for (int i = 0; i < len; i++) begin
                    if (i != 1) begin
                        logic [127:0] e, a;
                        e = {32'h1000_0000 + 32'(i * 256 + len * 16 + opt),
                             32'h2000_0000 + 32'(i * 512 + len * 16 + opt),
                             31'((i + 1) * 100 + opt), 1'(i % 2)};
                        a = {log_pci[k], log_loc[k], 8'd0, log_cnt[k], log_dir[k]};
                        chk(a == e, "R5 R4 R3 transfer fields", a, e);
                        k++;
                    end
                end
                // R8: count word cleared only in clear-count mode
                for (int i = 0; i < len; i++) begin
                    logic [31:0] m, e;
                    m = (i % 2 == 1) ? pci_mem[4 * (i + 1) + 2] : loc_mem[4 * (i + 1) + 2];
                    e = clr ? 32'h0 :
                        ((i == 1) ? 32'h0080_0000 : (32'hAB80_0000 | 32'((i + 1) * 100 + opt)));
                    chk(m == e, "R8 count word", m, e);
                end
                // R9 R10: interrupt routing and stickiness
                expirq = die || (len >= 2);
                repeat (3) @(negedge clk);
                chk({irq_pci, irq_local} == {expirq && sel, expirq && !sel},
                    "R9 irq route", {irq_pci, irq_local}, {expirq && sel, expirq && !sel});
                wr(3'd1, 32'h9);
                chk({irq_pci, irq_local} == 2'b00, "R10 clear", {irq_pci, irq_local}, 0);
            end
        end

        // R7: single transfer from registers, no descriptor reads
        wr(3'd0, 32'h2);
        wr(3'd2, 32'hCAFE_0000); wr(3'd3, 32'hBEEF_0010);
        wr(3'd4, 32'h123); wr(3'd5, 32'h8);
        n_xfr = 0; n_mrd = 0;
        wr(3'd1, 32'h3);
        wait_done("R7 single done");
        chk(n_xfr == 1 && n_mrd == 0, "R7 one transfer no fetch", {n_xfr, n_mrd}, {32'd1, 32'd0});
        chk({log_pci[0], log_loc[0], log_cnt[0], log_dir[0]} ==
            {32'hCAFE_0000, 32'hBEEF_0010, 23'h123, 1'b1}, "R7 fields",
            {log_pci[0], log_loc[0], log_cnt[0], log_dir[0]},
            {32'hCAFE_0000, 32'hBEEF_0010, 23'h123, 1'b1});
        chk(irq_local && !irq_pci, "R9 done irq local", {irq_pci, irq_local}, 2'b01);
        wr(3'd1, 32'h9);

        // R6: single zero-length run issues nothing but completes
        wr(3'd4, 32'h0);
        n_xfr = 0;
        wr(3'd1, 32'h3);
        wait_done("R6 zero single done");
        chk(n_xfr == 0, "R6 zero single no transfer", n_xfr, 0);
        wr(3'd1, 32'h9);

        // R11: abort of an active transfer
        hold_xfr = 1'b1;
        wr(3'd4, 32'h5);
        n_xfr = 0;
        wr(3'd1, 32'h3);
        repeat (4) @(negedge clk);
        rd(3'd1, v); chk(v == 32'h01, "R11 busy before abort", v, 32'h01);
        chk(xfr_req == 1'b1, "R11 request pending", xfr_req, 1);
        wr(3'd1, 32'h5);
        chk(xfr_req == 1'b0, "R11 request dropped", xfr_req, 0);
        rd(3'd1, v); chk(v == 32'h11, "R11 done after abort", v, 32'h11);
        hold_xfr = 1'b0;
        repeat (4) @(negedge clk);
        chk(n_xfr == 0 && !irq_pci && !irq_local, "R11 no transfer no irq",
            {n_xfr, irq_pci, irq_local}, 0);
        // R11: abort while idle has no effect
        wr(3'd1, 32'h5);
        rd(3'd1, v); chk(v == 32'h11, "R11 idle abort", v, 32'h11);

        finish_run();
    end

endmodule